// File: doc/BRIEF.md
# Downstream Credit Tracker

This block sits beside an instruction rename stage and works out, for every hardware thread, how much room is left in four downstream structures: the reorder buffer, the issue queue, the load queue and the store queue. Each structure reports its free-entry count now and then, each report marked by a valid flag. Between reports, some instructions have already been renamed but have not yet been dispatched. The tracker keeps running in-flight counters for all instructions, for loads and for stores. It subtracts what is still in flight from the last reported count, so that the rename stage never commits more work than the downstream side can take.

For each thread, every cycle, the block returns the number of instructions the stage may rename, a permission flag for loads and one for stores, a combinational stall indication, a registered hold state, and a three-bit stall-reason code. A small two-state machine per thread, with states `LANE_RUN` and `LANE_HOLD`, turns clamped or stalled cycles into a hold. That hold lasts until every stall condition has cleared. The rename tables and the rename stage's own sequencing stay outside the block.

Top module: `credtrk_top`

## Requirements
- R1: Effective ROB free is the current count minus (instructions in flight minus `disp_all` this cycle), computed as a signed value. The current count is the ROB report in a cycle whose valid flag is high, and the stored count otherwise. Effective IQ free is formed the same way from the IQ report.
- R2: Effective LQ free and effective SQ free use the shared LSQ report, the load-in-flight and store-in-flight counters, and `disp_ld` and `disp_st` respectively.
- R3: A stored count changes only on a clock edge at which its report is valid. After reset the stored counts hold the parameters ROB_INIT, IQ_INIT, LQ_INIT and SQ_INIT, and `rob_empty` is 1. `rob_empty` is registered: it takes the `rob_rpt_empty` value of a valid ROB report, and otherwise keeps its value.
- R4: `allow` is 0 in any of these cases: the smaller of effective ROB free and effective IQ free is zero or less, `stall` is high, or the thread is in `LANE_HOLD`. Otherwise `allow` is that smaller value, capped at `avail`.
- R5: A thread in `LANE_RUN` moves to `LANE_HOLD` on a clock edge where `stall` is high. It also moves to `LANE_HOLD` where the smaller effective free count is positive but below `avail`; this is the clamp case, and the clamped count is still granted in that cycle. From `LANE_HOLD` the thread returns to `LANE_RUN` at the first edge with `stall` low. `held` is 1 exactly in `LANE_HOLD`.
- R6: `ld_ok` is 1 exactly when effective LQ free is above zero. `st_ok` is 1 exactly when effective SQ free is above zero.
- R7: `why` takes the first matching entry of this list: 6 for `ext_stall`; 1 for ROB free ≤ 0; 2 for IQ free ≤ 0; 3 when LQ and SQ free are both ≤ 0; 5 for `regs_none`; in the clamp case, 2 if IQ free < ROB free and 1 otherwise; 3 when `head_ld` is high and LQ free ≤ 0; 4 when `head_st` is high and SQ free ≤ 0; otherwise 0.
- R8: `stall` is high exactly when any of the following holds: `ext_stall`, ROB free ≤ 0, IQ free ≤ 0, LQ and SQ free both ≤ 0, or `regs_none`.
- R9: Each in-flight counter rises by its renamed count and falls by its dispatched count on every clock edge. No counter may ever go below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rob_rpt_vld | input | NT | ROB report valid, per thread |
| rob_rpt_free | input | NT×CW | Reported ROB free entries |
| rob_rpt_empty | input | NT | Reported ROB empty flag |
| iq_rpt_vld | input | NT | IQ report valid |
| iq_rpt_free | input | NT×CW | Reported IQ free entries |
| lsq_rpt_vld | input | NT | Load/store report valid |
| lq_rpt_free | input | NT×CW | Reported LQ free entries |
| sq_rpt_free | input | NT×CW | Reported SQ free entries |
| disp_all | input | NT×AW | Instructions dispatched this cycle |
| disp_ld | input | NT×AW | Loads dispatched to LQ this cycle |
| disp_st | input | NT×AW | Stores dispatched to SQ this cycle |
| ren_all | input | NT×AW | Instructions renamed this cycle |
| ren_ld | input | NT×AW | Loads renamed this cycle |
| ren_st | input | NT×AW | Stores renamed this cycle |
| avail | input | NT×AW | Instructions waiting to be renamed |
| ext_stall | input | NT | Stall request from a later stage |
| regs_none | input | NT | No free physical registers |
| head_ld | input | NT | Next instruction is a load |
| head_st | input | NT | Next instruction is a store |
| allow | output | NT×AW | Instructions that may be renamed |
| ld_ok | output | NT | A load may be renamed |
| st_ok | output | NT | A store may be renamed |
| stall | output | NT | Stall condition this cycle |
| held | output | NT | Thread is in LANE_HOLD |
| why | output | NT×3 | Stall reason code |
| rob_empty | output | NT | Last reported ROB empty flag |

## Verification
An in-flight counter that has drifted shows up in the very cycle it goes wrong: `allow`, `ld_ok`, `st_ok`, `stall` and `why` all depend on it combinationally, and the next comparison is against a model that keeps its own counts. A stored report that is wrong, or a hold state that is wrong, shows one cycle after the edge that corrupted it, through `allow`, `held` or `rob_empty`. Both threads are driven at once with different inputs, so a mix-up between lanes changes visible outputs within a cycle.

// File: rtl/credtrk_pkg.sv
package credtrk_pkg;

    typedef enum logic [0:0] {
        LANE_RUN  = 1'b0,
        LANE_HOLD = 1'b1
    } lane_st_e;

    typedef enum logic [2:0] {
        WHY_NONE = 3'd0,
        WHY_ROB  = 3'd1,
        WHY_IQ   = 3'd2,
        WHY_LQ   = 3'd3,
        WHY_SQ   = 3'd4,
        WHY_REGS = 3'd5,
        WHY_EXT  = 3'd6
    } why_e;

endpackage

// File: rtl/credtrk_inflight.sv
module credtrk_inflight #(
    parameter int CW = 6,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] inc,
    input  logic [AW-1:0] dec,
    output logic [CW-1:0] count
);
    logic [CW-1:0] cnt_q;
    logic [CW:0]   sum;
    logic [CW:0]   dec_x;
    logic [CW:0]   nxt;

    always_comb begin
        sum   = {1'b0, cnt_q} + {{(CW + 1 - AW){1'b0}}, inc};
        dec_x = {{(CW + 1 - AW){1'b0}}, dec};
        nxt   = sum - dec_x;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= nxt[CW-1:0];
    end

    assign count = cnt_q;

    // R9
    inflight_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sum >= dec_x);

endmodule

// File: rtl/credtrk_credit.sv
module credtrk_credit #(
    parameter int CW   = 6,
    parameter int AW   = 3,
    parameter int INIT = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rpt_vld,
    input  logic [CW-1:0]       rpt_free,
    input  logic [CW-1:0]       inflight,
    input  logic [AW-1:0]       drained,
    output logic signed [CW+1:0] eff
);
    logic [CW-1:0] stored_q;
    logic [CW-1:0] cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stored_q <= CW'(INIT);
        else if (rpt_vld) stored_q <= rpt_free;
    end

    always_comb begin
        cur = rpt_vld ? rpt_free : stored_q;
        eff = $signed({2'b00, cur})
            - $signed({2'b00, inflight})
            + $signed({{(CW + 2 - AW){1'b0}}, drained});
    end

    // R3
    credit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rpt_vld |=> $stable(stored_q));

endmodule

// File: rtl/credtrk_lane.sv
module credtrk_lane
    import credtrk_pkg::*;
#(
    parameter int CW       = 6,
    parameter int AW       = 3,
    parameter int ROB_INIT = 32,
    parameter int IQ_INIT  = 16,
    parameter int LQ_INIT  = 8,
    parameter int SQ_INIT  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rob_vld,
    input  logic [CW-1:0] rob_free,
    input  logic          rob_emp_in,
    input  logic          iq_vld,
    input  logic [CW-1:0] iq_free,
    input  logic          lsq_vld,
    input  logic [CW-1:0] lq_free,
    input  logic [CW-1:0] sq_free,
    input  logic [AW-1:0] d_all,
    input  logic [AW-1:0] d_ld,
    input  logic [AW-1:0] d_st,
    input  logic [AW-1:0] r_all,
    input  logic [AW-1:0] r_ld,
    input  logic [AW-1:0] r_st,
    input  logic [AW-1:0] avail,
    input  logic          xstall,
    input  logic          noregs,
    input  logic          hd_ld,
    input  logic          hd_st,
    output logic [AW-1:0] allow,
    output logic          ld_ok,
    output logic          st_ok,
    output logic          stall,
    output logic          held,
    output logic [2:0]    why,
    output logic          rob_empty
);
    localparam int EW = CW + 2;

    logic [CW-1:0] ip_all, ip_ld, ip_st;
    logic signed [EW-1:0] e_rob, e_iq, e_lq, e_sq, min_f, avail_s;
    logic rob_out, iq_out, lq_out, sq_out, min_out, clamp, stall_now;
    lane_st_e state_q, state_d;
    logic rob_empty_q;

    credtrk_inflight #(.CW(CW), .AW(AW)) u_ip_all (
        .clk(clk), .rst_n(rst_n), .inc(r_all), .dec(d_all), .count(ip_all));
    credtrk_inflight #(.CW(CW), .AW(AW)) u_ip_ld (
        .clk(clk), .rst_n(rst_n), .inc(r_ld), .dec(d_ld), .count(ip_ld));
    credtrk_inflight #(.CW(CW), .AW(AW)) u_ip_st (
        .clk(clk), .rst_n(rst_n), .inc(r_st), .dec(d_st), .count(ip_st));

    credtrk_credit #(.CW(CW), .AW(AW), .INIT(ROB_INIT)) u_rob (
        .clk(clk), .rst_n(rst_n), .rpt_vld(rob_vld), .rpt_free(rob_free),
        .inflight(ip_all), .drained(d_all), .eff(e_rob));
    credtrk_credit #(.CW(CW), .AW(AW), .INIT(IQ_INIT)) u_iq (
        .clk(clk), .rst_n(rst_n), .rpt_vld(iq_vld), .rpt_free(iq_free),
        .inflight(ip_all), .drained(d_all), .eff(e_iq));
    credtrk_credit #(.CW(CW), .AW(AW), .INIT(LQ_INIT)) u_lq (
        .clk(clk), .rst_n(rst_n), .rpt_vld(lsq_vld), .rpt_free(lq_free),
        .inflight(ip_ld), .drained(d_ld), .eff(e_lq));
    credtrk_credit #(.CW(CW), .AW(AW), .INIT(SQ_INIT)) u_sq (
        .clk(clk), .rst_n(rst_n), .rpt_vld(lsq_vld), .rpt_free(sq_free),
        .inflight(ip_st), .drained(d_st), .eff(e_sq));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rob_empty_q <= 1'b1;
        else if (rob_vld) rob_empty_q <= rob_emp_in;
    end

    always_comb begin
        rob_out   = (e_rob <= 0);
        iq_out    = (e_iq  <= 0);
        lq_out    = (e_lq  <= 0);
        sq_out    = (e_sq  <= 0);
        min_f     = (e_iq < e_rob) ? e_iq : e_rob;
        min_out   = (min_f <= 0);
        avail_s   = $signed({{(EW - AW){1'b0}}, avail});
        clamp     = !min_out && (min_f < avail_s);
        stall_now = xstall | rob_out | iq_out | (lq_out & sq_out) | noregs;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LANE_RUN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LANE_RUN:  if (stall_now || clamp) state_d = LANE_HOLD;
            LANE_HOLD: if (!stall_now)         state_d = LANE_RUN;
            default:   state_d = LANE_RUN;
        endcase
    end

    // outputs
    always_comb begin
        allow = '0;
        unique case (state_q)
            LANE_RUN: begin
                if (!stall_now)
                    allow = clamp ? min_f[AW-1:0] : avail;
            end
            LANE_HOLD: allow = '0;
            default:   allow = '0;
        endcase

        if (xstall)                 why = WHY_EXT;
        else if (rob_out)           why = WHY_ROB;
        else if (iq_out)            why = WHY_IQ;
        else if (lq_out && sq_out)  why = WHY_LQ;
        else if (noregs)            why = WHY_REGS;
        else if (clamp)             why = (e_iq < e_rob) ? WHY_IQ : WHY_ROB;
        else if (hd_ld && lq_out)   why = WHY_LQ;
        else if (hd_st && sq_out)   why = WHY_SQ;
        else                        why = WHY_NONE;
    end

    assign ld_ok     = !lq_out;
    assign st_ok     = !sq_out;
    assign stall     = stall_now;
    assign held      = (state_q == LANE_HOLD);
    assign rob_empty = rob_empty_q;

    // R4
    allow_le_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        allow <= avail);

    // R4
    allow_zero_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_now |-> (allow == '0));

    // R5
    clamp_then_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (allow != '0 && allow < avail) |=> held);

    // R3
    rob_empty_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rob_vld |=> $stable(rob_empty));

endmodule

// File: rtl/credtrk_top.sv
module credtrk_top #(
    parameter int NT       = 2,
    parameter int CW       = 6,
    parameter int RW       = 4,
    parameter int ROB_INIT = 32,
    parameter int IQ_INIT  = 16,
    parameter int LQ_INIT  = 8,
    parameter int SQ_INIT  = 8,
    parameter int AW       = $clog2(RW + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NT-1:0]          rob_rpt_vld,
    input  logic [NT-1:0][CW-1:0]  rob_rpt_free,
    input  logic [NT-1:0]          rob_rpt_empty,
    input  logic [NT-1:0]          iq_rpt_vld,
    input  logic [NT-1:0][CW-1:0]  iq_rpt_free,
    input  logic [NT-1:0]          lsq_rpt_vld,
    input  logic [NT-1:0][CW-1:0]  lq_rpt_free,
    input  logic [NT-1:0][CW-1:0]  sq_rpt_free,
    input  logic [NT-1:0][AW-1:0]  disp_all,
    input  logic [NT-1:0][AW-1:0]  disp_ld,
    input  logic [NT-1:0][AW-1:0]  disp_st,
    input  logic [NT-1:0][AW-1:0]  ren_all,
    input  logic [NT-1:0][AW-1:0]  ren_ld,
    input  logic [NT-1:0][AW-1:0]  ren_st,
    input  logic [NT-1:0][AW-1:0]  avail,
    input  logic [NT-1:0]          ext_stall,
    input  logic [NT-1:0]          regs_none,
    input  logic [NT-1:0]          head_ld,
    input  logic [NT-1:0]          head_st,
    output logic [NT-1:0][AW-1:0]  allow,
    output logic [NT-1:0]          ld_ok,
    output logic [NT-1:0]          st_ok,
    output logic [NT-1:0]          stall,
    output logic [NT-1:0]          held,
    output logic [NT-1:0][2:0]     why,
    output logic [NT-1:0]          rob_empty
);
    for (genvar t = 0; t < NT; t++) begin : g_lane
        credtrk_lane #(
            .CW(CW), .AW(AW),
            .ROB_INIT(ROB_INIT), .IQ_INIT(IQ_INIT),
            .LQ_INIT(LQ_INIT), .SQ_INIT(SQ_INIT)
        ) u_lane (
            .clk(clk), .rst_n(rst_n),
            .rob_vld(rob_rpt_vld[t]), .rob_free(rob_rpt_free[t]),
            .rob_emp_in(rob_rpt_empty[t]),
            .iq_vld(iq_rpt_vld[t]), .iq_free(iq_rpt_free[t]),
            .lsq_vld(lsq_rpt_vld[t]), .lq_free(lq_rpt_free[t]),
            .sq_free(sq_rpt_free[t]),
            .d_all(disp_all[t]), .d_ld(disp_ld[t]), .d_st(disp_st[t]),
            .r_all(ren_all[t]), .r_ld(ren_ld[t]), .r_st(ren_st[t]),
            .avail(avail[t]), .xstall(ext_stall[t]), .noregs(regs_none[t]),
            .hd_ld(head_ld[t]), .hd_st(head_st[t]),
            .allow(allow[t]), .ld_ok(ld_ok[t]), .st_ok(st_ok[t]),
            .stall(stall[t]), .held(held[t]), .why(why[t]),
            .rob_empty(rob_empty[t])
        );
    end

endmodule

// File: tb/credtrk_top_test.sv
module credtrk_top_test;
    localparam int NT = 2;
    localparam int CW = 6;
    localparam int RW = 4;
    localparam int AW = 3;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NT-1:0]          rob_rpt_vld, rob_rpt_empty, iq_rpt_vld, lsq_rpt_vld;
    logic [NT-1:0][CW-1:0]  rob_rpt_free, iq_rpt_free, lq_rpt_free, sq_rpt_free;
    logic [NT-1:0][AW-1:0]  disp_all, disp_ld, disp_st, ren_all, ren_ld, ren_st, avail;
    logic [NT-1:0]          ext_stall, regs_none, head_ld, head_st;
    logic [NT-1:0][AW-1:0]  allow;
    logic [NT-1:0]          ld_ok, st_ok, stall, held, rob_empty;
    logic [NT-1:0][2:0]     why;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_rob[NT], m_iq[NT], m_lq[NT], m_sq[NT];
    int m_ip[NT], m_lip[NT], m_sip[NT];
    bit m_emp[NT], m_hold[NT];
    bit x_stall[NT], x_clamp[NT];

    always #(CLK_PERIOD / 2) clk = ~clk;

    credtrk_top #(.NT(NT), .CW(CW), .RW(RW)) uut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic zero_inputs();
        rob_rpt_vld = '0; rob_rpt_empty = '0; iq_rpt_vld = '0; lsq_rpt_vld = '0;
        rob_rpt_free = '0; iq_rpt_free = '0; lq_rpt_free = '0; sq_rpt_free = '0;
        disp_all = '0; disp_ld = '0; disp_st = '0;
        ren_all = '0; ren_ld = '0; ren_st = '0; avail = '0;
        ext_stall = '0; regs_none = '0; head_ld = '0; head_st = '0;
    endtask

    task automatic model_check();
        for (int t = 0; t < NT; t++) begin
            int er, ei, el, es, mn, av, ea, ew;
            bit ro, io, lo, so, clampv, stl;
            er = (rob_rpt_vld[t] ? int'(rob_rpt_free[t]) : m_rob[t]) - m_ip[t] + int'(disp_all[t]);
            ei = (iq_rpt_vld[t] ? int'(iq_rpt_free[t]) : m_iq[t]) - m_ip[t] + int'(disp_all[t]);
            el = (lsq_rpt_vld[t] ? int'(lq_rpt_free[t]) : m_lq[t]) - m_lip[t] + int'(disp_ld[t]);
            es = (lsq_rpt_vld[t] ? int'(sq_rpt_free[t]) : m_sq[t]) - m_sip[t] + int'(disp_st[t]);
            ro = er <= 0; io = ei <= 0; lo = el <= 0; so = es <= 0;
            mn = (ei < er) ? ei : er;
            av = int'(avail[t]);
            clampv = (mn > 0) && (mn < av);
            stl = ext_stall[t] || ro || io || (lo && so) || regs_none[t];
            ea = (m_hold[t] || stl) ? 0 : (clampv ? mn : av);
            if (ext_stall[t]) ew = 6;
            else if (ro) ew = 1;
            else if (io) ew = 2;
            else if (lo && so) ew = 3;
            else if (regs_none[t]) ew = 5;
            else if (clampv) ew = (ei < er) ? 2 : 1;
            else if (head_ld[t] && lo) ew = 3;
            else if (head_st[t] && so) ew = 4;
            else ew = 0;
            chk(int'(allow[t]) == ea, "R1 R4 R9 allow", int'(allow[t]), ea);
            chk(ld_ok[t] == !lo, "R2 R6 ld_ok", int'(ld_ok[t]), int'(!lo));
            chk(st_ok[t] == !so, "R2 R6 st_ok", int'(st_ok[t]), int'(!so));
            chk(stall[t] == stl, "R8 stall", int'(stall[t]), int'(stl));
            chk(held[t] == m_hold[t], "R5 held", int'(held[t]), int'(m_hold[t]));
            chk(int'(why[t]) == ew, "R7 why", int'(why[t]), ew);
            chk(rob_empty[t] == m_emp[t], "R3 rob_empty", int'(rob_empty[t]), int'(m_emp[t]));
            x_stall[t] = stl;
            x_clamp[t] = clampv;
        end
    endtask

    task automatic model_update();
        for (int t = 0; t < NT; t++) begin
            if (rob_rpt_vld[t]) begin
                m_rob[t] = int'(rob_rpt_free[t]);
                m_emp[t] = rob_rpt_empty[t];
            end
            if (iq_rpt_vld[t]) m_iq[t] = int'(iq_rpt_free[t]);
            if (lsq_rpt_vld[t]) begin
                m_lq[t] = int'(lq_rpt_free[t]);
                m_sq[t] = int'(sq_rpt_free[t]);
            end
            m_ip[t]  += int'(ren_all[t]) - int'(disp_all[t]);
            m_lip[t] += int'(ren_ld[t]) - int'(disp_ld[t]);
            m_sip[t] += int'(ren_st[t]) - int'(disp_st[t]);
            if (m_hold[t]) m_hold[t] = x_stall[t];
            else           m_hold[t] = x_stall[t] || x_clamp[t];
        end
    endtask

    task automatic step();
        #1;
        model_check();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    function automatic int lim(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic rand_inputs();
        for (int t = 0; t < NT; t++) begin
            int ra, rl, rs;
            rob_rpt_vld[t]   = ($urandom % 4) == 0;
            rob_rpt_free[t]  = CW'($urandom % 24);
            rob_rpt_empty[t] = $urandom % 2;
            iq_rpt_vld[t]    = ($urandom % 4) == 0;
            iq_rpt_free[t]   = CW'($urandom % 14);
            lsq_rpt_vld[t]   = ($urandom % 4) == 0;
            lq_rpt_free[t]   = CW'($urandom % 7);
            sq_rpt_free[t]   = CW'($urandom % 7);
            avail[t]         = AW'($urandom % (RW + 1));
            ext_stall[t]     = ($urandom % 8) == 0;
            regs_none[t]     = ($urandom % 8) == 0;
            head_ld[t]       = $urandom % 2;
            head_st[t]       = $urandom % 2;
            ra = (m_ip[t] < 40) ? int'($urandom % (RW + 1)) : 0;
            rl = (m_lip[t] < 40) ? int'($urandom % (ra + 1)) : 0;
            rs = (m_sip[t] < 40) ? int'($urandom % (ra - rl + 1)) : 0;
            ren_all[t] = AW'(ra); ren_ld[t] = AW'(rl); ren_st[t] = AW'(rs);
            if ($urandom % 2) begin
                disp_all[t] = AW'(lim(RW, m_ip[t] + ra));
                disp_ld[t]  = AW'(lim(RW, m_lip[t] + rl));
                disp_st[t]  = AW'(lim(RW, m_sip[t] + rs));
            end else begin
                disp_all[t] = AW'($urandom % (lim(RW, m_ip[t] + ra) + 1));
                disp_ld[t]  = AW'($urandom % (lim(RW, m_lip[t] + rl) + 1));
                disp_st[t]  = AW'($urandom % (lim(RW, m_sip[t] + rs) + 1));
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < NT; t++) begin
            m_rob[t] = 32; m_iq[t] = 16; m_lq[t] = 8; m_sq[t] = 8;
            m_ip[t] = 0; m_lip[t] = 0; m_sip[t] = 0;
            m_emp[t] = 1; m_hold[t] = 0;
        end
        zero_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 reset state, nothing waiting
        step();

        // R4 plain grant up to avail
        avail[0] = 3; avail[1] = 4;
        step();

        // R5 ROB clamp on thread 0, IQ clamp on thread 1
        rob_rpt_vld[0] = 1; rob_rpt_free[0] = 2; rob_rpt_empty[0] = 0;
        iq_rpt_vld[1] = 1;  iq_rpt_free[1] = 1;
        step();
        rob_rpt_vld = '0; iq_rpt_vld = '0;
        step();
        step();

        // R9 in-flight eats credit, then dispatch returns it
        ren_all[0] = 2; ren_ld[0] = 1; ren_st[0] = 1;
        step();
        ren_all = '0; ren_ld = '0; ren_st = '0;
        step();
        disp_all[0] = 2; disp_ld[0] = 1; disp_st[0] = 1;
        step();
        disp_all = '0; disp_ld = '0; disp_st = '0;

        // R6 R7 empty load queue with a load at the head, then both empty
        lsq_rpt_vld[1] = 1; lq_rpt_free[1] = 0; sq_rpt_free[1] = 3; head_ld[1] = 1;
        step();
        lsq_rpt_vld[1] = 1; lq_rpt_free[1] = 0; sq_rpt_free[1] = 0;
        step();
        lsq_rpt_vld = '0; head_ld = '0;

        // R8 external stall and register exhaustion
        ext_stall[0] = 1; regs_none[1] = 1;
        step();
        ext_stall = '0; regs_none = '0;
        step();
        step();

        for (int i = 0; i < 4000; i++) begin
            rand_inputs();
            step();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule